// File: doc/BRIEF.md
# Byte-Stream Program RAM Bootloader

This block fills program memory from a host that delivers one byte per transfer. It collects every three accepted bytes into a 24-bit value, least significant byte first. The first value is the number of program words to follow. The second value is the program address where they go. Each later value is one program word, written to the next program RAM location. When the last word has been written, the block raises a single-cycle start request carrying the load address, so the core begins execution where the code was placed.

The host can cut the data phase short with an abort flag. The block then drops any half-built word and issues the start request at once. The loader does nothing unless the boot-mode pins select byte-stream loading. After it has issued its one start request, it stays inert until the next reset.

Top module: `prog_boot_loader`

## Requirements
- R1: While the block is idle, it starts loading only when `bootMode` equals 3'b111. With any other mode value, `byteReady` stays low and no RAM write or start pulse occurs.
- R2: A byte is accepted on a rising clock edge where `byteValid` and `byteReady` are both high. Three accepted bytes form one 24-bit value, with the first byte in bits 7:0, the second in bits 15:8 and the third in bits 23:16.
- R3: The first assembled value is the word count N. The second is the load address A.
- R4: The next N values are written to RAM at addresses A, A+1, … A+N-1, in order. Each write raises `ramWe` for exactly one cycle, starting in the cycle after the third byte of that word is accepted.
- R5: After the N-th write, `startPulse` is high for exactly one cycle, in the same cycle as that last `ramWe`, and `startAddr` equals A.
- R6: A count of zero writes nothing. `startPulse` follows in the cycle after the last address byte is accepted.
- R7: If `abortFlag` is high at a clock edge during the data phase, any byte offered at that edge is refused and a partly assembled word is discarded unwritten. `startPulse` with `startAddr` = A follows in the next cycle.
- R8: `abortFlag` has no effect while the count and address are being received.
- R9: After the start pulse, the block stays done until reset. `byteReady` is low, and no further RAM write or start pulse occurs, whatever the inputs do.
- R10: Out of reset, `byteReady`, `ramWe` and `startPulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bootMode | input | 3 | Boot mode select; 3'b111 enables loading |
| byteValid | input | 1 | Host byte present |
| byteData | input | 8 | Host byte |
| byteReady | output | 1 | Loader accepts a byte this cycle |
| abortFlag | input | 1 | Host request to stop loading and start execution |
| ramWe | output | 1 | Program RAM write enable, one cycle per word |
| ramAddr | output | ADDR_W | Program RAM write address |
| ramData | output | 24 | Program RAM write data |
| startPulse | output | 1 | One-cycle start-execution request |
| startAddr | output | 24 | Execution start address (the load address) |

## Verification
The bound checker watches, on every cycle, that loading begins only after the boot mode is seen, that successive RAM writes land at incrementing addresses, and that each write lasts a single cycle. It also checks that the start request appears once and for one cycle only, and that the block stays silent once done. Byte order within a word, the exact number of words written, the address carried with the start request, the zero-count shortcut, and the handling of the abort flag in the header and the data phase all depend on stimulus. Only the directed scenarios of the bench show these.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 3;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;
  localparam int MODE_W     = 3;
  localparam int CNT_W      = $clog2(WORD_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_ADDR,
    ST_DATA,
    ST_FIRE,
    ST_DONE
  } bootState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeByte;
    logic clearByte;
    logic latchCount;
    logic latchAddr;
    logic writeWord;
  } dpCtrl_t;
endpackage

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import boot_pkg::*;
#(
  parameter logic [MODE_W-1:0] BOOT_MODE = 3'b111
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] bootMode,
  input  logic              byteValid,
  input  logic              abortFlag,
  input  logic              wordFull,
  input  logic              countZero,
  input  logic              lastWord,
  output logic              byteReady,
  output logic              startPulse,
  output dpCtrl_t           ctl
);
  bootState_t state, stateNext;
  logic loading, abortNow, accept, wordEnd;

  always_comb begin
    loading  = (state == ST_COUNT) || (state == ST_ADDR) || (state == ST_DATA);
    abortNow = (state == ST_DATA) && abortFlag;
    accept   = loading && byteValid && !abortNow;
    wordEnd  = accept && wordFull;

    ctl.takeByte   = accept;
    ctl.clearByte  = abortNow;
    ctl.latchCount = wordEnd && (state == ST_COUNT);
    ctl.latchAddr  = wordEnd && (state == ST_ADDR);
    ctl.writeWord  = wordEnd && (state == ST_DATA);

    byteReady  = loading && !abortNow;
    startPulse = (state == ST_FIRE);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (bootMode == BOOT_MODE) stateNext = ST_COUNT;
      ST_COUNT: if (wordEnd) stateNext = ST_ADDR;
      ST_ADDR:  if (wordEnd) stateNext = countZero ? ST_FIRE : ST_DATA;
      ST_DATA: begin
        if (abortNow) stateNext = ST_FIRE;
        else if (wordEnd && lastWord) stateNext = ST_FIRE;
      end
      ST_FIRE:  stateNext = ST_DONE;
      ST_DONE:  stateNext = ST_DONE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/boot_dpath.sv
module boot_dpath
  import boot_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] byteData,
  input  dpCtrl_t           ctl,
  output logic              wordFull,
  output logic              countZero,
  output logic              lastWord,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [WORD_W-1:0] ramData,
  output logic [WORD_W-1:0] startAddr
);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(WORD_BYTES - 1);

  logic [CNT_W-1:0]  byteCnt;
  logic [WORD_W-1:0] shiftReg, assembled, remaining, loadAddr;
  logic [ADDR_W-1:0] wrPtr;

  always_comb begin
    assembled = {byteData, shiftReg[WORD_W-1:BYTE_W]};
    wordFull  = (byteCnt == LAST_BYTE);
    countZero = (remaining == '0);
    lastWord  = (remaining == WORD_W'(1));
    startAddr = loadAddr;
  end

  // byte assembly, least significant byte first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt  <= '0;
      shiftReg <= '0;
    end else if (ctl.clearByte) begin
      byteCnt  <= '0;
    end else if (ctl.takeByte) begin
      shiftReg <= assembled;
      byteCnt  <= wordFull ? '0 : byteCnt + 1'b1;
    end
  end

  // header registers and write pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
      loadAddr  <= '0;
      wrPtr     <= '0;
    end else begin
      if (ctl.latchCount) remaining <= assembled;
      if (ctl.latchAddr) begin
        loadAddr <= assembled;
        wrPtr    <= assembled[ADDR_W-1:0];
      end
      if (ctl.writeWord) begin
        remaining <= remaining - 1'b1;
        wrPtr     <= wrPtr + 1'b1;
      end
    end
  end

  // registered RAM write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramWe   <= 1'b0;
      ramAddr <= '0;
      ramData <= '0;
    end else begin
      ramWe <= ctl.writeWord;
      if (ctl.writeWord) begin
        ramAddr <= wrPtr;
        ramData <= assembled;
      end
    end
  end
endmodule

// File: rtl/prog_boot_loader.sv
module prog_boot_loader
  import boot_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        bootMode,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  output logic              byteReady,
  input  logic              abortFlag,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [23:0]       ramData,
  output logic              startPulse,
  output logic [23:0]       startAddr
);
  dpCtrl_t ctl;
  logic wordFull, countZero, lastWord;

  boot_ctrl #(.BOOT_MODE(3'b111)) u_ctrl (
    .clk(clk), .rstN(rstN), .bootMode(bootMode), .byteValid(byteValid),
    .abortFlag(abortFlag), .wordFull(wordFull), .countZero(countZero),
    .lastWord(lastWord), .byteReady(byteReady), .startPulse(startPulse),
    .ctl(ctl)
  );

  boot_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .byteData(byteData), .ctl(ctl),
    .wordFull(wordFull), .countZero(countZero), .lastWord(lastWord),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData),
    .startAddr(startAddr)
  );
endmodule

// File: rtl/prog_boot_loader_chk.sv
module prog_boot_loader_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        bootMode,
  input logic              byteReady,
  input logic              ramWe,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              startPulse
);
  logic haveWr, doneSeen;
  logic [ADDR_W-1:0] lastWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haveWr   <= 1'b0;
      lastWr   <= '0;
      doneSeen <= 1'b0;
    end else begin
      if (ramWe) begin
        haveWr <= 1'b1;
        lastWr <= ramAddr;
      end
      if (startPulse) doneSeen <= 1'b1;
    end
  end

  // R1
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(byteReady) |-> ($past(bootMode) == 3'b111));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && haveWr) |-> (ramAddr == ADDR_W'(lastWr + 1'b1)));

  // R4
  we_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |=> !ramWe);

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  // R9
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> !doneSeen);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneSeen |-> (!byteReady && !ramWe && !startPulse));
endmodule

bind prog_boot_loader prog_boot_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .bootMode(bootMode), .byteReady(byteReady),
  .ramWe(ramWe), .ramAddr(ramAddr), .startPulse(startPulse)
);

// File: tb/test_prog_boot_loader.sv
`timescale 1ns/1ps
module test_prog_boot_loader;
  localparam int ADDR_W = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] bootMode = 3'b000;
  logic byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic abortFlag = 1'b0;
  logic byteReady, ramWe, startPulse;
  logic [ADDR_W-1:0] ramAddr;
  logic [23:0] ramData, startAddr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  int wrCount = 0;
  int pulseCount = 0;
  logic [23:0] pulseAddr;
  logic [23:0] wrAddr [16];
  logic [23:0] wrData [16];

  always #10 clk = ~clk;

  prog_boot_loader #(.ADDR_W(ADDR_W)) i_prog_boot_loader (
    .clk(clk), .rstN(rstN), .bootMode(bootMode), .byteValid(byteValid),
    .byteData(byteData), .byteReady(byteReady), .abortFlag(abortFlag),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData),
    .startPulse(startPulse), .startAddr(startAddr)
  );

  always @(negedge clk) begin
    cycles++;
    if (ramWe) begin
      if (wrCount < 16) begin
        wrAddr[wrCount] = ramAddr;
        wrData[wrCount] = ramData;
      end
      wrCount++;
    end
    if (startPulse) begin
      pulseCount++;
      pulseAddr = startAddr;
    end
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [2:0] mode);
    @(negedge clk);
    rstN = 1'b0; byteValid = 1'b0; abortFlag = 1'b0; bootMode = mode;
    repeat (2) @(negedge clk);
    wrCount = 0; pulseCount = 0;
    rstN = 1'b1;
  endtask

  task automatic sendByte(input logic [7:0] b);
    int waitN;
    waitN = 0;
    @(negedge clk);
    while (!byteReady && waitN < 20) begin
      @(negedge clk);
      waitN++;
    end
    check(byteReady, "R2 byteReady before byte", 32'(byteReady), 1);
    byteValid = 1'b1;
    byteData = b;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic sendWord(input logic [23:0] w);
    sendByte(w[7:0]);
    sendByte(w[15:8]);
    sendByte(w[23:16]);
  endtask

  task automatic testReset();
    doReset(3'b000);
    @(negedge clk);
    check(!byteReady, "R10 byteReady after reset", 32'(byteReady), 0);
    check(!ramWe, "R10 ramWe after reset", 32'(ramWe), 0);
    check(!startPulse, "R10 startPulse after reset", 32'(startPulse), 0);
  endtask

  task automatic testModeGate();
    doReset(3'b011);
    byteValid = 1'b1; byteData = 8'h5a;
    repeat (10) begin
      @(negedge clk);
      check(!byteReady, "R1 idle with wrong mode", 32'(byteReady), 0);
    end
    byteValid = 1'b0;
    check(wrCount == 0 && pulseCount == 0, "R1 no activity", 32'(wrCount + pulseCount), 0);
    bootMode = 3'b111;
    repeat (2) @(negedge clk);
    check(byteReady, "R1 starts when mode selects", 32'(byteReady), 1);
  endtask

  task automatic testNormal();
    logic [23:0] words [4];
    words[0] = 24'h123456; words[1] = 24'hABCDEF;
    words[2] = 24'h000001; words[3] = 24'hFF8000;
    doReset(3'b111);
    sendWord(24'd4);
    sendWord(24'h000100);
    for (int i = 0; i < 4; i++) sendWord(words[i]);
    repeat (3) @(negedge clk);
    check(wrCount == 4, "R4 write count", 32'(wrCount), 4);
    for (int i = 0; i < 4; i++) begin
      check(wrAddr[i] == 24'h000100 + 24'(i), "R4 write address", 32'(wrAddr[i]),
            32'(24'h000100 + 24'(i)));
      check(wrData[i] == words[i], "R2 byte order in word", 32'(wrData[i]), 32'(words[i]));
    end
    check(pulseCount == 1, "R5 one start pulse", 32'(pulseCount), 1);
    check(pulseAddr == 24'h000100, "R5 start address", 32'(pulseAddr), 32'h100);
    byteValid = 1'b1;
    repeat (5) @(negedge clk);
    byteValid = 1'b0;
    check(!byteReady && wrCount == 4 && pulseCount == 1, "R9 stays done",
          32'(wrCount), 4);
  endtask

  task automatic testZeroCount();
    doReset(3'b111);
    sendWord(24'd0);
    sendByte(8'hEF);
    sendByte(8'hCD);
    sendByte(8'hAB);
    check(startPulse, "R6 pulse right after address", 32'(startPulse), 1);
    repeat (3) @(negedge clk);
    check(wrCount == 0, "R6 no writes", 32'(wrCount), 0);
    check(pulseAddr == 24'hABCDEF, "R6 start address", 32'(pulseAddr), 32'hABCDEF);
  endtask

  task automatic testAbortData();
    doReset(3'b111);
    sendWord(24'd5);
    sendWord(24'h000200);
    sendWord(24'h111111);
    sendWord(24'h222222);
    sendByte(8'h33);
    abortFlag = 1'b1;
    byteValid = 1'b1; byteData = 8'h44;
    @(negedge clk);
    abortFlag = 1'b0; byteValid = 1'b0;
    check(startPulse, "R7 pulse after abort", 32'(startPulse), 1);
    check(startAddr == 24'h000200, "R7 start address", 32'(startAddr), 32'h200);
    byteValid = 1'b1; byteData = 8'h55;
    repeat (6) @(negedge clk);
    byteValid = 1'b0;
    check(wrCount == 2, "R7 partial word dropped", 32'(wrCount), 2);
    check(pulseCount == 1, "R9 single pulse after abort", 32'(pulseCount), 1);
  endtask

  task automatic testAbortHeader();
    doReset(3'b111);
    abortFlag = 1'b1;
    sendWord(24'd2);
    sendWord(24'h000040);
    abortFlag = 1'b0;
    check(pulseCount == 0, "R8 abort ignored in header", 32'(pulseCount), 0);
    sendWord(24'hC0FFEE);
    sendWord(24'h0BEEF0);
    repeat (3) @(negedge clk);
    check(wrCount == 2, "R8 loading continued", 32'(wrCount), 2);
    check(wrAddr[1] == 24'h000041 && wrData[1] == 24'h0BEEF0, "R3 header order",
          32'(wrAddr[1]), 32'h41);
    check(pulseAddr == 24'h000040, "R5 start address after header abort",
          32'(pulseAddr), 32'h40);
  endtask

  initial begin
    testReset();
    testModeGate();
    testNormal();
    testZeroCount();
    testAbortData();
    testAbortHeader();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule